// File: doc/BRIEF.md
# Watchdog with Safe-Frequency Fallback

This block guards a system after its clock frequency has been reprogrammed. Once armed, it counts down a programmed number of long steps, each made of a fixed number of slow `tick` strobes. Software restarts the countdown with a kick or by writing a new count. If the countdown is allowed to run out, the block raises a sticky alarm and drives an active-low system reset for a fixed number of ticks. For as long as the alarm stays set, it replaces the normal frequency code with a stored safe code.

The step length comes from a time-base strap. A strap value of 1 selects the short step of `FAST_STEP_TICKS` ticks, and a strap value of 0 selects a step `SLOW_STEP_MULT` times as long. With a 1 ms tick and the default parameters, the short step is 290 ms and the long step is 580 ms. A hardware-enable strap is captured once after reset. A software enable bit replaces the strap value whenever the override flag is set.

The control state machine has five states:
- `ST_LATCH` captures the straps and always moves to `ST_IDLE` on the next clock.
- `ST_IDLE` moves to `ST_COUNT` and loads the full count when the watchdog is enabled and the count is non-zero.
- `ST_COUNT` falls back to `ST_IDLE` when the watchdog is disabled or the count becomes 0, and moves to `ST_RESET` when the last step ends.
- `ST_RESET` drives the reset pulse and moves to `ST_SAFE` after `RST_PULSE_TICKS` ticks.
- `ST_SAFE` holds the safe code and returns to `ST_IDLE` when `alarm_clr` is asserted.

Top module: `wdt_safe_fallback`

## Requirements
- R1: After reset, `sys_rst_n` is 1, `alarm` is 0 and `freq_code` equals `norm_code`.
- R2: The watchdog is enabled by `sw_en` when `sw_override`=1, and otherwise by the value `strap_hw_en` had in the first clock after reset. Later changes of the strap are ignored. A disabled watchdog never expires.
- R3: From arming or reload, expiry happens on exactly count × step ticks. The step is `FAST_STEP_TICKS` ticks when `strap_tb_fast` was 1 at capture, and `FAST_STEP_TICKS`×`SLOW_STEP_MULT` ticks when it was 0.
- R4: The count register holds `CNT_DEFAULT` (16) after reset until `cnt_wr` loads `cnt_val`.
- R5: A `kick` pulse or a `cnt_wr` pulse reloads the full count and restarts the current step, including a step that is partly elapsed.
- R6: A count of 0 disables expiry. The output stays inactive for any number of ticks.
- R7: On expiry, `alarm` becomes 1 and `sys_rst_n` goes low on the same clock. `sys_rst_n` stays low for exactly `RST_PULSE_TICKS` ticks and then returns to 1.
- R8: `freq_code` equals `safe_code` while `alarm`=1, and equals `norm_code` while `alarm`=0.
- R9: `alarm` stays 1 until an `alarm_clr` pulse arrives after the reset pulse has ended. `alarm_clr` during the pulse has no effect. After clearing, the countdown restarts with the full count.
- R10: Expiry and reset timing advance only on clocks where `tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock time-base strobe |
| strap_hw_en | input | 1 | Hardware enable strap, captured after reset |
| strap_tb_fast | input | 1 | Time-base strap, captured after reset (1 = short step) |
| cnt_val | input | CNT_W | Step count to load |
| cnt_wr | input | 1 | Load strobe for `cnt_val`; also restarts the countdown |
| kick | input | 1 | Restart strobe |
| sw_en | input | 1 | Software enable value |
| sw_override | input | 1 | 1 = `sw_en` replaces the strap enable |
| alarm_clr | input | 1 | Clears the alarm once the reset pulse has ended |
| norm_code | input | CODE_W | Frequency code used in normal operation |
| safe_code | input | CODE_W | Frequency code forced while the alarm is set |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| alarm | output | 1 | Sticky timeout status |
| freq_code | output | CODE_W | Selected frequency code |

## Verification
The bench builds the block with `FAST_STEP_TICKS`=3, `SLOW_STEP_MULT`=2 and `RST_PULSE_TICKS`=4, and keeps the default count of 16. With these values every timeout is a few dozen ticks long. That short length lets the bench sweep both time bases across several counts and compare each expiry against count × step exactly. It also brings the default-count timeout, kicks in the middle of a step, the zero count and every enable combination within reach of one short run.

// File: rtl/wdt_fallback_pkg.sv
package wdt_fallback_pkg;
    typedef enum logic [2:0] {
        ST_LATCH = 3'd0,
        ST_IDLE  = 3'd1,
        ST_COUNT = 3'd2,
        ST_RESET = 3'd3,
        ST_SAFE  = 3'd4
    } wdt_state_e;
endpackage

// File: rtl/wdt_step_timer.sv
// Divides the slow tick into steps of one of two lengths.
module wdt_step_timer #(
    parameter int FAST_TICKS = 290,
    parameter int SLOW_MULT  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic clr,
    input  logic fast_sel,
    output logic step_end
);
    localparam int SLOW_TICKS = FAST_TICKS * SLOW_MULT;
    localparam int PW         = $clog2(SLOW_TICKS + 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim;

    assign lim      = fast_sel ? PW'(FAST_TICKS - 1) : PW'(SLOW_TICKS - 1);
    assign step_end = run && !clr && tick && (pre_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr || !run) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= (pre_q == lim) ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_ctrl_fsm.sv
// Arming, countdown, reset pulse and alarm control.
module wdt_ctrl_fsm
    import wdt_fallback_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int CNT_DEFAULT = 16,
    parameter int RST_TICKS   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wd_en,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             kick,
    input  logic             alarm_clr,
    input  logic             step_end,
    output logic             latch_now,
    output logic             timer_run,
    output logic             timer_clr,
    output logic             rst_active,
    output logic             alarm
);
    localparam int RW = $clog2(RST_TICKS + 1);

    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_reg_q;
    logic [CNT_W-1:0] left_q;
    logic [RW-1:0]    rst_cnt_q;
    logic             alarm_q;
    logic [CNT_W-1:0] next_cnt;
    logic             reload;

    assign next_cnt = cnt_wr ? cnt_val : cnt_reg_q;
    assign reload   = kick || cnt_wr;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LATCH: state_d = ST_IDLE;
            ST_IDLE: begin
                if (wd_en && (next_cnt != '0)) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!wd_en || (next_cnt == '0))
                    state_d = ST_IDLE;
                else if (!reload && step_end && (left_q == CNT_W'(1)))
                    state_d = ST_RESET;
            end
            ST_RESET: begin
                if (tick && (rst_cnt_q == RW'(RST_TICKS - 1))) state_d = ST_SAFE;
            end
            ST_SAFE: begin
                if (alarm_clr) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LATCH;
        else        state_q <= state_d;
    end

    // Counters and alarm
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_reg_q <= CNT_W'(CNT_DEFAULT);
            left_q    <= '0;
            rst_cnt_q <= '0;
            alarm_q   <= 1'b0;
        end else begin
            cnt_reg_q <= next_cnt;
            if (state_q == ST_IDLE && state_d == ST_COUNT)
                left_q <= next_cnt;
            else if (state_q == ST_COUNT) begin
                if (reload)        left_q <= next_cnt;
                else if (step_end) left_q <= left_q - 1'b1;
            end
            if (state_q != ST_RESET) rst_cnt_q <= '0;
            else if (tick)           rst_cnt_q <= rst_cnt_q + 1'b1;
            if (state_q == ST_COUNT && state_d == ST_RESET)
                alarm_q <= 1'b1;
            else if (state_q == ST_SAFE && alarm_clr)
                alarm_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        latch_now  = (state_q == ST_LATCH);
        timer_run  = (state_q == ST_COUNT);
        timer_clr  = reload;
        rst_active = (state_q == ST_RESET);
        alarm      = alarm_q;
    end
endmodule

// File: rtl/wdt_safe_fallback.sv
module wdt_safe_fallback #(
    parameter int FAST_STEP_TICKS = 290,
    parameter int SLOW_STEP_MULT  = 2,
    parameter int CNT_W           = 8,
    parameter int CNT_DEFAULT     = 16,
    parameter int RST_PULSE_TICKS = 8,
    parameter int CODE_W          = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              strap_hw_en,
    input  logic              strap_tb_fast,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_wr,
    input  logic              kick,
    input  logic              sw_en,
    input  logic              sw_override,
    input  logic              alarm_clr,
    input  logic [CODE_W-1:0] norm_code,
    input  logic [CODE_W-1:0] safe_code,
    output logic              sys_rst_n,
    output logic              alarm,
    output logic [CODE_W-1:0] freq_code
);
    logic hw_en_q, tb_fast_q;
    logic latch_now, timer_run, timer_clr, step_end, rst_active, wd_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_en_q   <= 1'b0;
            tb_fast_q <= 1'b0;
        end else if (latch_now) begin
            hw_en_q   <= strap_hw_en;
            tb_fast_q <= strap_tb_fast;
        end
    end

    assign wd_en = sw_override ? sw_en : hw_en_q;

    wdt_step_timer #(
        .FAST_TICKS (FAST_STEP_TICKS),
        .SLOW_MULT  (SLOW_STEP_MULT)
    ) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (timer_run),
        .clr      (timer_clr),
        .fast_sel (tb_fast_q),
        .step_end (step_end)
    );

    wdt_ctrl_fsm #(
        .CNT_W       (CNT_W),
        .CNT_DEFAULT (CNT_DEFAULT),
        .RST_TICKS   (RST_PULSE_TICKS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wd_en      (wd_en),
        .cnt_wr     (cnt_wr),
        .cnt_val    (cnt_val),
        .kick       (kick),
        .alarm_clr  (alarm_clr),
        .step_end   (step_end),
        .latch_now  (latch_now),
        .timer_run  (timer_run),
        .timer_clr  (timer_clr),
        .rst_active (rst_active),
        .alarm      (alarm)
    );

    assign sys_rst_n = !rst_active;
    assign freq_code = alarm ? safe_code : norm_code;
endmodule

// File: rtl/wdt_safe_fallback_chk.sv
module wdt_safe_fallback_chk #(
    parameter int RST_PULSE_TICKS = 8,
    parameter int CODE_W          = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              alarm_clr,
    input logic [CODE_W-1:0] norm_code,
    input logic [CODE_W-1:0] safe_code,
    input logic              sys_rst_n,
    input logic              alarm,
    input logic [CODE_W-1:0] freq_code
);
    logic [15:0] low_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         low_ticks <= '0;
        else if (sys_rst_n) low_ticks <= '0;
        else if (tick)      low_ticks <= low_ticks + 16'd1;
    end

    AST_RST_NEEDS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> alarm); // R7
    AST_ALARM_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> !sys_rst_n); // R7
    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        low_ticks <= 16'(RST_PULSE_TICKS)); // R7
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !alarm_clr) |=> alarm); // R9
    AST_SAFE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (freq_code == safe_code)); // R8
    AST_NORM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm |-> (freq_code == norm_code)); // R8
    AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n) |-> $past(tick)); // R10
endmodule

bind wdt_safe_fallback wdt_safe_fallback_chk #(
    .RST_PULSE_TICKS (RST_PULSE_TICKS),
    .CODE_W          (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .alarm_clr (alarm_clr),
    .norm_code (norm_code),
    .safe_code (safe_code),
    .sys_rst_n (sys_rst_n),
    .alarm     (alarm),
    .freq_code (freq_code)
);

// File: tb/wdt_safe_fallback_bench.sv
module wdt_safe_fallback_bench;
    localparam int FAST  = 3;
    localparam int MULT  = 2;
    localparam int RSTT  = 4;
    localparam int NORM  = 5'h0A;
    localparam int SAFE  = 5'h15;

    logic       clk = 1'b0;
    logic       rst_n, tick, strap_hw_en, strap_tb_fast, cnt_wr, kick;
    logic       sw_en, sw_override, alarm_clr;
    logic [7:0] cnt_val;
    logic [4:0] norm_code, safe_code;
    logic       sys_rst_n, alarm;
    logic [4:0] freq_code;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wdt_safe_fallback #(
        .FAST_STEP_TICKS (FAST),
        .SLOW_STEP_MULT  (MULT),
        .CNT_W           (8),
        .CNT_DEFAULT     (16),
        .RST_PULSE_TICKS (RSTT),
        .CODE_W          (5)
    ) u_wdt_safe_fallback (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .strap_hw_en (strap_hw_en), .strap_tb_fast (strap_tb_fast),
        .cnt_val (cnt_val), .cnt_wr (cnt_wr), .kick (kick),
        .sw_en (sw_en), .sw_override (sw_override), .alarm_clr (alarm_clr),
        .norm_code (norm_code), .safe_code (safe_code),
        .sys_rst_n (sys_rst_n), .alarm (alarm), .freq_code (freq_code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic hw, input logic tbf);
        rst_n = 1'b0; tick = 1'b0; cnt_wr = 1'b0; kick = 1'b0; cnt_val = '0;
        sw_en = 1'b0; sw_override = 1'b0; alarm_clr = 1'b0;
        strap_hw_en = hw; strap_tb_fast = tbf;
        norm_code = 5'(NORM); safe_code = 5'(SAFE);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_ticks(input int k);
        for (int i = 0; i < k; i++) do_tick();
    endtask

    task automatic write_cnt(input int v);
        @(negedge clk) begin cnt_val = 8'(v); cnt_wr = 1'b1; end
        @(negedge clk) cnt_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic kick_p();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic clr_p();
        @(negedge clk) alarm_clr = 1'b1;
        @(negedge clk) alarm_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ticks_to_low(output int n);
        n = 0;
        while (sys_rst_n && n < 1000) begin do_tick(); n++; end
    endtask

    task automatic ticks_to_high(output int n);
        n = 0;
        while (!sys_rst_n && n < 1000) begin do_tick(); n++; end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, m;
        // R1 reset state
        apply_reset(1'b1, 1'b1);
        check("R1 sys_rst_n", int'(sys_rst_n), 1);
        check("R1 alarm", int'(alarm), 0);
        check("R1 freq_code", int'(freq_code), NORM);

        // R4 default count of 16, short step
        ticks_to_low(n);
        check("R4 default timeout", n, 16 * FAST);
        check("R7 alarm at expiry", int'(alarm), 1);
        check("R8 safe code", int'(freq_code), SAFE);
        do_tick();
        clr_p();
        check("R9 clear ignored during pulse", int'(alarm), 1);
        ticks_to_high(m);
        check("R7 pulse length", m + 1, RSTT);
        run_ticks(10);
        check("R9 alarm sticky", int'(alarm), 1);
        check("R9 no second pulse", int'(sys_rst_n), 1);
        check("R8 safe code held", int'(freq_code), SAFE);
        clr_p();
        check("R9 alarm cleared", int'(alarm), 0);
        check("R8 normal code restored", int'(freq_code), NORM);
        ticks_to_low(n);
        check("R9 restart full count", n, 16 * FAST);

        // R3 sweep of time bases and counts
        for (int tb = 0; tb < 2; tb++) begin
            for (int ci = 0; ci < 5; ci++) begin
                int c;
                int step;
                c = (ci == 0) ? 1 : (ci == 1) ? 2 : (ci == 2) ? 3 : (ci == 3) ? 5 : 9;
                step = (tb == 1) ? FAST : FAST * MULT;
                apply_reset(1'b1, 1'(tb));
                write_cnt(c);
                ticks_to_low(n);
                check("R3 timeout", n, c * step);
                ticks_to_high(m);
                check("R7 pulse length", m, RSTT);
                clr_p();
                ticks_to_low(n);
                check("R9 timeout after clear", n, c * step);
            end
        end

        // R5 kick near expiry
        apply_reset(1'b1, 1'b1);
        write_cnt(3);
        run_ticks(7);
        kick_p();
        ticks_to_low(n);
        check("R5 kick reload", n, 3 * FAST);
        // R5 kick in mid-step restarts the step
        apply_reset(1'b1, 1'b1);
        write_cnt(2);
        run_ticks(2);
        kick_p();
        ticks_to_low(n);
        check("R5 mid-step kick", n, 2 * FAST);
        // R5 count write restarts
        apply_reset(1'b1, 1'b1);
        write_cnt(4);
        run_ticks(5);
        write_cnt(2);
        ticks_to_low(n);
        check("R5 write reload", n, 2 * FAST);

        // R6 zero count
        apply_reset(1'b1, 1'b1);
        write_cnt(0);
        run_ticks(60);
        check("R6 no expiry rst", int'(sys_rst_n), 1);
        check("R6 no expiry alarm", int'(alarm), 0);
        write_cnt(1);
        ticks_to_low(n);
        check("R6 re-armed", n, FAST);

        // R2 enable selection
        apply_reset(1'b0, 1'b1);
        write_cnt(1);
        run_ticks(20);
        check("R2 strap disabled", int'(alarm), 0);
        @(negedge clk) begin sw_override = 1'b1; sw_en = 1'b1; end
        repeat (3) @(negedge clk);
        ticks_to_low(n);
        check("R2 software enable", n, FAST);
        apply_reset(1'b1, 1'b1);
        strap_hw_en = 1'b0;
        write_cnt(1);
        ticks_to_low(n);
        check("R2 strap change ignored", n, FAST);
        apply_reset(1'b1, 1'b1);
        @(negedge clk) begin sw_override = 1'b1; sw_en = 1'b0; end
        write_cnt(1);
        run_ticks(20);
        check("R2 software disable", int'(alarm), 0);
        check("R10 no reset without expiry", int'(sys_rst_n), 1);

        // R10 clocks without tick do not advance
        apply_reset(1'b1, 1'b1);
        write_cnt(1);
        run_ticks(FAST - 1);
        repeat (200) @(negedge clk);
        check("R10 idle clocks", int'(sys_rst_n), 1);
        do_tick();
        check("R10 final tick expires", int'(sys_rst_n), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule